// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog that software keeps alive through a small byte-addressed register port. A prescaler divides the system clock into ticks. Each tick that arrives while the timer is running lowers a 10-bit counter by one. When a tick finds the counter at zero, the counter expires and loads its programmed initial value again.

The first expiry sets a first-timeout status flag, and that flag drives a level interrupt request. If the counter expires a second time while that flag is still set, the block records a second-timeout flag. It also sends a one-cycle system reset request, unless software has set the no-reboot control bit. Software services the timer by writing the reload register. To restart the two-stage sequence, software clears the first-timeout flag, which is write-one-to-clear, and reloads the counter.

All registers are 16 bits wide. The port uses the `bus_addr`, `bus_wr` and `bus_wdata` inputs. A write to the selected register takes effect at the clock edge where `bus_wr` is high. Reads are combinational, and `bus_rdata` shows the register that `bus_addr` selects. An address that matches no register reads as zero.

Top module: `two_stage_wdt`

## Requirements
- R1: After reset, the control register (offset 0x08) reads 0x0801 and the initial-value register (offset 0x12) reads 50. The count register (offset 0x00) reads 50, both status registers (offsets 0x04 and 0x06) read 0, and `irq_first` and `rst_req` are low.
- R2: While the timer runs, the count drops by one every PRESCALE clock cycles. A reload write restarts the prescaler phase, so the first decrement lands on the PRESCALE-th edge after the reload edge.
- R3: Control bit 11 is the halt bit. While it is 1 the count does not change, except when a reload write arrives.
- R4: In the initial-value register at 0x12, bits 9:0 hold the initial count. Bits 15:10 are stored on a write and read back unchanged.
- R5: A write to 0x12 whose bits 9:0 are below 4 is ignored as a whole, and the register keeps its previous contents.
- R6: A write of any data to offset 0x00 loads the count with the initial value. A read of 0x00 returns the count in bits 9:0, with zeros above. If a reload write and a tick fall in the same cycle, the reload wins.
- R7: On the first expiry (a tick finds the count at 0 while bit 3 of 0x04 is clear), the count reloads and bit 3 of 0x04 is set. `irq_first` equals that bit.
- R8: An expiry while bit 3 of 0x04 is set reloads the count and sets bit 1 of 0x06. If no-reboot is 0, it also raises `rst_req` for exactly one cycle, in the same cycle the status bit appears.
- R9: Control bit 0 is the no-reboot bit. When it is 1, a second expiry raises no `rst_req`, but bit 1 of 0x06 is still set.
- R10: Writing 1 to bit 3 of 0x04 or to bit 1 of 0x06 clears that bit, and writing 0 there has no effect. If bit 3 is cleared and the counter reloaded, the next expiry counts as a first expiry again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register selected by `bus_addr` |
| irq_first | output | 1 | Level interrupt request, set by the first timeout |
| rst_req | output | 1 | One-cycle system reset request on a second timeout |

## Verification
The assertions assume the bus inputs are known at every rising edge and that a write strobe lasts a single cycle per access. They also assume PRESCALE is at least 1, so that expiries are always several ticks apart and a reset pulse can never be followed directly by another. The stimulus changes the bus inputs only just after a rising edge and reads only at falling edges. It reloads the counter right after starting the timer, so every tick and expiry lands on an edge known from the reload edge. It programs only valid initial values before letting the timer run, which keeps the dwell between expiries well above one cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Register geometry shared by every level
    localparam int unsigned REG_W = 16;

    // Byte offsets of the mapped registers
    localparam int unsigned OFS_COUNT  = 32'h00;
    localparam int unsigned OFS_STAT_A = 32'h04;
    localparam int unsigned OFS_STAT_B = 32'h06;
    localparam int unsigned OFS_CTRL   = 32'h08;
    localparam int unsigned OFS_INIT   = 32'h12;

    // Bit positions inside the mapped registers
    localparam int unsigned BIT_FIRST    = 3;
    localparam int unsigned BIT_SECOND   = 1;
    localparam int unsigned BIT_HALT     = 11;
    localparam int unsigned BIT_NOREBOOT = 0;

    // Write-decoded commands from the register port to the counter core
    typedef struct packed {
        logic reload;
        logic clr_first;
        logic clr_second;
    } wdt_cmd_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PS_W-1:0] cnt;
    } ps_state_t;

    ps_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == LAST);

    // Phase counter never leaves its divide range (R2)
    assert_prescale_range_R2: assert property (
        @(posedge clk) disable iff (!rst_n) st_q.cnt <= LAST
    );

    // A restart puts the phase at zero on the next edge (R2)
    assert_prescale_restart_R2: assert property (
        @(posedge clk) disable iff (!rst_n) restart |=> st_q.cnt == '0
    );

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned INIT_RST  = 50,
    parameter int unsigned MIN_INIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              first_sts,
    input  logic              second_sts,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              halt,
    output logic              noreboot,
    output logic [CNT_W-1:0]  init_val,
    output wdt_cmd_t          cmd
);

    localparam int unsigned HI_W = REG_W - CNT_W;
    localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(MIN_INIT);

    typedef struct packed {
        logic            halt;
        logic            noreboot;
        logic [HI_W-1:0] init_hi;
        logic [CNT_W-1:0] init_lo;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic sel_count, sel_stat_a, sel_stat_b, sel_ctrl, sel_init;
    logic init_ok;

    always_comb begin
        sel_count  = (bus_addr == ADDR_W'(OFS_COUNT));
        sel_stat_a = (bus_addr == ADDR_W'(OFS_STAT_A));
        sel_stat_b = (bus_addr == ADDR_W'(OFS_STAT_B));
        sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
        sel_init   = (bus_addr == ADDR_W'(OFS_INIT));
        init_ok    = (bus_wdata[CNT_W-1:0] >= MIN_VAL);
    end

    // Next-state of the software-owned registers
    always_comb begin
        st_d = st_q;
        if (bus_wr && sel_ctrl) begin
            st_d.halt     = bus_wdata[BIT_HALT];
            st_d.noreboot = bus_wdata[BIT_NOREBOOT];
        end
        if (bus_wr && sel_init && init_ok) begin
            st_d.init_hi = bus_wdata[REG_W-1:CNT_W];
            st_d.init_lo = bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.halt     <= 1'b1;
            st_q.noreboot <= 1'b1;
            st_q.init_hi  <= '0;
            st_q.init_lo  <= CNT_W'(INIT_RST);
        end else begin
            st_q <= st_d;
        end
    end

    // Command strobes toward the counter core
    always_comb begin
        cmd.reload     = bus_wr && sel_count;
        cmd.clr_first  = bus_wr && sel_stat_a && bus_wdata[BIT_FIRST];
        cmd.clr_second = bus_wr && sel_stat_b && bus_wdata[BIT_SECOND];
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (sel_count) begin
            bus_rdata[CNT_W-1:0] = count;
        end
        if (sel_stat_a) begin
            bus_rdata[BIT_FIRST] = first_sts;
        end
        if (sel_stat_b) begin
            bus_rdata[BIT_SECOND] = second_sts;
        end
        if (sel_ctrl) begin
            bus_rdata[BIT_HALT]     = st_q.halt;
            bus_rdata[BIT_NOREBOOT] = st_q.noreboot;
        end
        if (sel_init) begin
            bus_rdata = {st_q.init_hi, st_q.init_lo};
        end
    end

    assign halt     = st_q.halt;
    assign noreboot = st_q.noreboot;
    assign init_val = st_q.init_lo;

    // The stored initial count never drops below the floor (R5)
    assert_init_floor_R5: assert property (
        @(posedge clk) disable iff (!rst_n) st_q.init_lo >= MIN_VAL
    );

    // A rejected initial-value write leaves the register untouched (R5)
    assert_init_reject_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_init && !init_ok) |=> $stable(st_q)
    );

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned INIT_RST = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             noreboot,
    input  logic [CNT_W-1:0] init_val,
    input  wdt_cmd_t         cmd,
    output logic [CNT_W-1:0] count,
    output logic             first_sts,
    output logic             second_sts,
    output logic             rst_req
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             first;
        logic             second;
        logic             rst;
    } cd_state_t;

    cd_state_t st_d, st_q;

    logic step;
    logic expire;

    always_comb begin
        step   = tick && !halt && !cmd.reload;
        expire = step && (st_q.count == '0);

        st_d     = st_q;
        st_d.rst = 1'b0;

        // Count: software reload outranks the tick
        if (cmd.reload) begin
            st_d.count = init_val;
        end else if (step) begin
            if (expire) begin
                st_d.count = init_val;
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
            end
        end

        // Write-one-to-clear first, hardware set afterwards so a set wins
        if (cmd.clr_first) begin
            st_d.first = 1'b0;
        end
        if (cmd.clr_second) begin
            st_d.second = 1'b0;
        end

        if (expire) begin
            if (!st_q.first) begin
                st_d.first = 1'b1;
            end else begin
                st_d.second = 1'b1;
                st_d.rst    = !noreboot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count  <= CNT_W'(INIT_RST);
            st_q.first  <= 1'b0;
            st_q.second <= 1'b0;
            st_q.rst    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count      = st_q.count;
    assign first_sts  = st_q.first;
    assign second_sts = st_q.second;
    assign rst_req    = st_q.rst;

    // Halted and not reloaded: the count holds (R3)
    assert_halt_freeze_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (halt && !cmd.reload) |=> $stable(st_q.count)
    );

    // Reload loads the programmed initial count (R6)
    assert_reload_load_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        cmd.reload |=> (st_q.count == $past(init_val))
    );

    // A reset request always comes with the second-timeout flag (R8)
    assert_rst_has_status_R8: assert property (
        @(posedge clk) disable iff (!rst_n) st_q.rst |-> st_q.second
    );

    // The reset request lasts one cycle (R8)
    assert_rst_single_R8: assert property (
        @(posedge clk) disable iff (!rst_n) st_q.rst |=> !st_q.rst
    );

    // No reset request while no-reboot was set (R9)
    assert_noreboot_gate_R9: assert property (
        @(posedge clk) disable iff (!rst_n) st_q.rst |-> !$past(noreboot)
    );

    // The first-timeout flag only falls on a clearing write (R10)
    assert_first_clear_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(st_q.first) |-> $past(cmd.clr_first)
    );

    // The second-timeout flag only falls on a clearing write (R10)
    assert_second_clear_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(st_q.second) |-> $past(cmd.clr_second)
    );

endmodule

// File: rtl/two_stage_wdt.sv
module two_stage_wdt
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned CNT_W      = 10,
    parameter int unsigned PRESCALE   = 60_000_000,
    parameter int unsigned INIT_TICKS = 50,
    parameter int unsigned MIN_INIT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq_first,
    output logic              rst_req
);

    logic             tick;
    logic             halt;
    logic             noreboot;
    logic [CNT_W-1:0] init_val;
    logic [CNT_W-1:0] count;
    logic             first_sts;
    logic             second_sts;
    wdt_cmd_t         cmd;

    wdt_prescaler #(
        .PRESCALE (PRESCALE)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cmd.reload),
        .tick    (tick)
    );

    wdt_regs #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .INIT_RST (INIT_TICKS),
        .MIN_INIT (MIN_INIT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .count      (count),
        .first_sts  (first_sts),
        .second_sts (second_sts),
        .bus_rdata  (bus_rdata),
        .halt       (halt),
        .noreboot   (noreboot),
        .init_val   (init_val),
        .cmd        (cmd)
    );

    wdt_countdown #(
        .CNT_W    (CNT_W),
        .INIT_RST (INIT_TICKS)
    ) u_countdown (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .halt       (halt),
        .noreboot   (noreboot),
        .init_val   (init_val),
        .cmd        (cmd),
        .count      (count),
        .first_sts  (first_sts),
        .second_sts (second_sts),
        .rst_req    (rst_req)
    );

    assign irq_first = first_sts;

endmodule

// File: tb/two_stage_wdt_tb_top.sv
module two_stage_wdt_tb_top;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned PS     = 4;

    localparam logic [ADDR_W-1:0] A_COUNT = 5'h00;
    localparam logic [ADDR_W-1:0] A_STA   = 5'h04;
    localparam logic [ADDR_W-1:0] A_STB   = 5'h06;
    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h08;
    localparam logic [ADDR_W-1:0] A_INIT  = 5'h12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic              irq_first;
    logic              rst_req;

    logic rd_chk = 1'b0;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   rst_pulses = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #5 clk = ~clk;

    two_stage_wdt #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (10),
        .PRESCALE   (PS),
        .INIT_TICKS (50),
        .MIN_INIT   (4)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_first (irq_first),
        .rst_req   (rst_req)
    );

    // Monitor: pops expected read data and compares it at the falling edge
    always @(negedge clk) begin
        if (rd_chk) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL scoreboard: read with no expected item, got %h expected none", bus_rdata);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                n_cmp++;
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
        if (rst_n && rst_req) rst_pulses++;
    end

    task automatic check_bit(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: one-cycle write, captured at the second rising edge of the task
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(posedge clk);
        #1;
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    // Driver: read sampled after the next rising edge; expected item queued
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [15:0] e, input string tag);
        exp_item_t it;
        @(posedge clk);
        #1;
        bus_addr = a;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
        rd_chk = 1'b1;
        @(negedge clk);
        #1;
        rd_chk = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state
        check_bit(irq_first, 1'b0, "R1 irq_first after reset");
        check_bit(rst_req, 1'b0, "R1 rst_req after reset");
        rd(A_CTRL, 16'h0801, "R1 control reset");
        rd(A_INIT, 16'd50, "R1 initial value reset");
        rd(A_COUNT, 16'd50, "R1 count reset");
        rd(A_STA, 16'h0000, "R1 first status reset");
        rd(A_STB, 16'h0000, "R1 second status reset");

        // R3: halted out of reset, count frozen
        repeat (40) @(posedge clk);
        rd(A_COUNT, 16'd50, "R3 halted count frozen");

        // R4 / R5: initial-value register
        wr(A_INIT, 16'h0003);
        rd(A_INIT, 16'd50, "R5 value 3 ignored");
        wr(A_INIT, 16'hFC08);
        rd(A_INIT, 16'hFC08, "R4 upper bits kept, value 8");
        wr(A_INIT, 16'hFC02);
        rd(A_INIT, 16'hFC08, "R5 value 2 ignored");
        wr(A_COUNT, 16'h0000);
        rd(A_COUNT, 16'd8, "R6 reload while halted");

        // R6: reload collides with a tick; reload wins
        wr(A_CTRL, 16'h0000);
        wr(A_COUNT, 16'hABCD);          // edge E
        repeat (PS - 2) @(posedge clk);
        wr(A_COUNT, 16'h0000);          // edge E+PS, tick cycle
        rd(A_COUNT, 16'd8, "R6 reload beats tick");
        repeat (9) @(posedge clk);
        rd(A_COUNT, 16'd6, "R2 two ticks after reload");

        // R3: halt while running
        wr(A_CTRL, 16'h0800);
        repeat (20) @(posedge clk);
        rd(A_COUNT, 16'd5, "R3 halted mid-run");

        // R7 / R8: two-stage expiry, reset allowed
        wr(A_CTRL, 16'h0000);
        wr(A_COUNT, 16'h0000);          // edge E
        repeat (34) @(posedge clk);
        rd(A_COUNT, 16'd0, "R2 count at zero before expiry");
        check_bit(irq_first, 1'b0, "R7 irq low before expiry");
        rd(A_STA, 16'h0008, "R7 first status set at expiry");
        check_bit(irq_first, 1'b1, "R7 irq follows first status");
        rd(A_COUNT, 16'd8, "R7 count reloaded after expiry");
        repeat (33) @(posedge clk);
        rd(A_STB, 16'h0000, "R8 second status clear before second expiry");
        check_bit(rst_req, 1'b0, "R8 no reset before second expiry");
        rd(A_STB, 16'h0002, "R8 second status set");
        check_bit(rst_req, 1'b1, "R8 reset pulse with status");
        @(negedge clk);
        check_bit(rst_req, 1'b0, "R8 reset pulse one cycle");

        // R10: write-one-to-clear
        wr(A_CTRL, 16'h0800);
        wr(A_STA, 16'h0000);
        rd(A_STA, 16'h0008, "R10 writing zero keeps status");
        wr(A_STA, 16'h0008);
        rd(A_STA, 16'h0000, "R10 first status cleared");
        check_bit(irq_first, 1'b0, "R7 irq drops with status");
        wr(A_STB, 16'h0002);
        rd(A_STB, 16'h0000, "R10 second status cleared");

        // R9: no-reboot suppresses the pulse, status still recorded
        wr(A_CTRL, 16'h0001);
        wr(A_COUNT, 16'h0000);
        repeat (80) @(posedge clk);
        rd(A_STB, 16'h0002, "R9 second status set under no-reboot");
        rd(A_STA, 16'h0008, "R9 first status set under no-reboot");
        check_int(rst_pulses, 1, "R9 no extra reset pulse");

        // R10: clear plus reload restarts the sequence
        wr(A_CTRL, 16'h0800);
        wr(A_STA, 16'h0008);
        wr(A_STB, 16'h0002);
        wr(A_CTRL, 16'h0000);
        wr(A_COUNT, 16'h0000);
        repeat (40) @(posedge clk);
        wr(A_STA, 16'h0008);
        wr(A_COUNT, 16'h0000);
        repeat (40) @(posedge clk);
        rd(A_STA, 16'h0008, "R10 restart gives first-stage expiry");
        rd(A_STB, 16'h0000, "R10 restart no second expiry");
        check_int(rst_pulses, 1, "R10 restart no reset pulse");

        @(negedge clk);
        check_int(exp_q.size(), 0, "scoreboard drained");
        finish_run();
    end

endmodule